// File: doc/BRIEF.md
# Serial EEPROM Boot Image Loader

After reset this block copies a fixed-size program image from a three-wire serial EEPROM into an on-chip boot RAM. The processor core must not run until the copy is complete. Each byte is a separate serial transaction: the loader raises chip select and sends a start bit, the two-bit read opcode and an 11-bit byte address. It then clocks eight data bits back in, drops chip select and presents the byte on a one-cycle RAM write port. The EEPROM byte at address N goes to RAM location N, so the image runs from address 0x0000 once `done` is high.

The serial clock comes from the system clock through a divider. `CLK_HALF_DIV` sets each serial half period in system cycles, so the EEPROM's timing limits can be met at any system frequency. The `END_PAUSE` parameter picks how a byte ends. With `END_PAUSE=1`, the engine passes through a finishing state that holds chip select low for one extra half period before it returns to idle. With `END_PAUSE=0`, it goes idle as soon as the last data bit is in. The system holds the core in reset, or stalls it, until `done` goes high.

Top module: `eeprom_boot_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ee_cs`, `ee_sclk`, `ee_mosi`, `ram_we` and `done` are all 0 after that edge.
- R2: Until `start` is seen high, chip select stays low and no RAM write occurs.
- R3: Each transaction sends 14 command bits, MSB first: 1 (start), then 1, 0 (read opcode), then the 11-bit EEPROM address. Transaction k (counting from 0) uses address k.
- R4: Chip select is high for exactly 22 rising serial-clock edges per transaction: 14 command bits, then 8 data bits.
- R5: `ee_mosi` changes only while `ee_sclk` is low, which means on a falling edge or before the first rising edge. The EEPROM drives each data bit after a falling edge. The loader samples it on the next rising edge and assembles the byte MSB first.
- R6: `ee_sclk` is low whenever `ee_cs` is low. Chip select drops after every byte and rises again for the next one, so there is one chip-select rise per byte.
- R7: Every high phase of `ee_sclk` lasts exactly `CLK_HALF_DIV` system cycles.
- R8: Exactly `IMAGE_BYTES` writes occur. Each write is a one-cycle `ram_we` pulse. Addresses ascend from 0, and RAM location N receives EEPROM byte N.
- R9: `done` rises on the cycle after the last write, stays high until reset, and no write occurs while it is high.
- R10: `start` is ignored while a load is in progress and after `done`.
- R11: Between bytes, chip select is low for exactly `CLK_HALF_DIV` cycles longer with `END_PAUSE=1` than with `END_PAUSE=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin loading the image (sampled while idle) |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sclk | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | Command bits to the EEPROM |
| ee_miso | input | 1 | Data bits from the EEPROM |
| ram_we | output | 1 | Boot RAM write enable, one-cycle pulse |
| ram_addr | output | $clog2(IMAGE_BYTES) | Boot RAM write address |
| ram_wdata | output | DATA_W | Boot RAM write data |
| done | output | 1 | Image fully loaded; release the core |

## Verification
Assertions check the per-cycle rules on every cycle:
- the serial clock stays low while chip select is low;
- `ee_mosi` is frozen while the serial clock is high;
- the serial clock changes only on a divider tick;
- writes are single-cycle pulses;
- `done` is sticky, never coincides with a write, and follows the write to the last address.

The bench scenarios cover what spans whole transactions. A behavioural EEPROM model decodes each 14-bit command and counts edges per chip-select window. The bench compares all RAM locations against the image. It measures half-period length and the inter-byte chip-select gap for both end-of-byte variants, and shows that `start` pulses during and after a load change nothing.

// File: rtl/boot_loader_pkg.sv
// Package: shared state encodings and serial command constants for the
// boot loader. Assumes an EEPROM read command of start bit + 2-bit opcode.
package boot_loader_pkg;

    localparam logic       SER_START_BIT = 1'b1;
    localparam logic [1:0] SER_READ_OP   = 2'b10;
    localparam int         SER_HDR_BITS  = 3;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_ARM,
        FR_SHIFT,
        FR_PAUSE
    } frame_state_t;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_READ,
        LD_WRITE,
        LD_DONE
    } load_state_t;

endpackage

// File: rtl/ee_sclk_divider.sv
// Serial clock divider: emits a one-cycle tick every HALF_DIV system
// cycles; each tick marks one serial half-period boundary.
// Assumes HALF_DIV >= 1; with 1 the tick is permanently high.
module ee_sclk_divider #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (HALF_DIV <= 1) begin : g_fast
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;

            // Free-running count; wraps after HALF_DIV cycles.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == LAST);

            // R7: ticks are isolated pulses when the divide ratio exceeds one
            a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ee_frame_engine.sv
// Frame engine: runs one read transaction per `go` pulse. It raises chip
// select, shifts out start/opcode/address MSB first (changing data only
// after falling edges), then samples DATA_W bits on rising edges. When done
// it drops chip select and pulses byte_valid. With END_PAUSE != 0 it waits
// one extra half period (FR_PAUSE) before going idle.
// Assumes `go` only arrives while idle and `tick` comes from the divider.
module ee_frame_engine
    import boot_loader_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int END_PAUSE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    input  logic              miso,
    output logic              cs,
    output logic              sclk,
    output logic              mosi,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data
);

    localparam int CMD_W = SER_HDR_BITS + ADDR_W;
    localparam int TOTAL = CMD_W + DATA_W;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] CMD_CNT = CW'(CMD_W);
    localparam logic [CW-1:0] END_CNT = CW'(TOTAL);

    frame_state_t      st;
    logic [CMD_W-1:0]  cmd_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [CW-1:0]     bit_cnt;
    logic              cs_q;
    logic              sclk_q;
    logic              valid_q;

    // Transaction sequencer: chip select, serial clock, shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= FR_IDLE;
            cmd_sr  <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
            cs_q    <= 1'b0;
            sclk_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (st)
                FR_IDLE: begin
                    if (go) begin
                        cmd_sr  <= {SER_START_BIT, SER_READ_OP, addr};
                        bit_cnt <= '0;
                        cs_q    <= 1'b1;
                        st      <= FR_ARM;
                    end
                end
                FR_ARM: begin
                    if (tick) begin
                        st <= FR_SHIFT;
                    end
                end
                FR_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q  <= 1'b1;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt >= CMD_CNT) begin
                                rx_sr <= {rx_sr[DATA_W-2:0], miso};
                            end
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_cnt == END_CNT) begin
                                cs_q <= 1'b0;
                                if (END_PAUSE != 0) begin
                                    st <= FR_PAUSE;
                                end else begin
                                    st      <= FR_IDLE;
                                    valid_q <= 1'b1;
                                end
                            end else begin
                                cmd_sr <= cmd_sr << 1;
                            end
                        end
                    end
                end
                FR_PAUSE: begin
                    if (tick) begin
                        st      <= FR_IDLE;
                        valid_q <= 1'b1;
                    end
                end
                default: st <= FR_IDLE;
            endcase
        end
    end

    assign cs         = cs_q;
    assign sclk       = sclk_q;
    assign mosi       = cmd_sr[CMD_W-1];
    assign byte_valid = valid_q;
    assign byte_data  = rx_sr;

    // R6: serial clock is parked low outside a transaction
    a_r6_sclk_low_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sclk);

    // R5: command line is frozen while the serial clock is high
    a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R7: serial clock only moves on a divider tick
    a_r7_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sclk));

    // R4: the bit counter never runs past one full transaction
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cs |-> (bit_cnt <= END_CNT));

endmodule

// File: rtl/eeprom_boot_loader.sv
// Boot loader top: after `start`, reads IMAGE_BYTES consecutive EEPROM
// bytes (addresses 0..IMAGE_BYTES-1) and writes each into boot RAM at the
// same index, then raises `done` permanently until reset.
// Assumes the RAM accepts a write on any cycle and EE_ADDR_W >= RAM_AW.
module eeprom_boot_loader
    import boot_loader_pkg::*;
#(
    parameter int CLK_HALF_DIV = 4,
    parameter int IMAGE_BYTES  = 256,
    parameter int EE_ADDR_W    = 11,
    parameter int DATA_W       = 8,
    parameter int END_PAUSE    = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    output logic                           ee_cs,
    output logic                           ee_sclk,
    output logic                           ee_mosi,
    input  logic                           ee_miso,
    output logic                           ram_we,
    output logic [$clog2(IMAGE_BYTES)-1:0] ram_addr,
    output logic [DATA_W-1:0]              ram_wdata,
    output logic                           done
);

    localparam int RAM_AW = $clog2(IMAGE_BYTES);
    localparam logic [RAM_AW-1:0] LAST_IDX = RAM_AW'(IMAGE_BYTES - 1);

    logic              tick;
    logic              go_q;
    logic              byte_valid;
    logic [DATA_W-1:0] byte_data;
    load_state_t       st;
    logic [RAM_AW-1:0] idx;
    logic              we_q;
    logic [RAM_AW-1:0] waddr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done_q;

    ee_sclk_divider #(
        .HALF_DIV (CLK_HALF_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ee_frame_engine #(
        .ADDR_W    (EE_ADDR_W),
        .DATA_W    (DATA_W),
        .END_PAUSE (END_PAUSE)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .go         (go_q),
        .addr       (EE_ADDR_W'(idx)),
        .miso       (ee_miso),
        .cs         (ee_cs),
        .sclk       (ee_sclk),
        .mosi       (ee_mosi),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    // Byte loop: request a byte, write it to RAM, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= LD_IDLE;
            idx     <= '0;
            go_q    <= 1'b0;
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (st)
                LD_IDLE: begin
                    if (start) begin
                        idx  <= '0;
                        go_q <= 1'b1;
                        st   <= LD_READ;
                    end
                end
                LD_READ: begin
                    if (byte_valid) begin
                        we_q    <= 1'b1;
                        waddr_q <= idx;
                        wdata_q <= byte_data;
                        st      <= LD_WRITE;
                    end
                end
                LD_WRITE: begin
                    we_q <= 1'b0;
                    if (idx == LAST_IDX) begin
                        done_q <= 1'b1;
                        st     <= LD_DONE;
                    end else begin
                        idx  <= idx + 1'b1;
                        go_q <= 1'b1;
                        st   <= LD_READ;
                    end
                end
                LD_DONE: begin
                    st <= LD_DONE;
                end
                default: st <= LD_IDLE;
            endcase
        end
    end

    assign ram_we    = we_q;
    assign ram_addr  = waddr_q;
    assign ram_wdata = wdata_q;
    assign done      = done_q;

    // R8: each write is a single-cycle pulse
    a_r8_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R9: done is sticky until reset
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R9: no RAM write once the load is reported complete
    a_r9_no_write_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ram_we);

    // R9: done rises right after the write to the last location
    a_r9_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(ram_we) && ($past(ram_addr) == LAST_IDX)));

    // R2: no serial activity while waiting for start
    a_r2_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LD_IDLE) |-> (!ee_cs && !ram_we));

endmodule

// File: tb/tb_eeprom_boot_loader.sv
package tb_img_pkg;
    function automatic logic [7:0] img_byte(input int a);
        int v;
        v = (a * 37 + 11) ^ (a >> 3);
        return v[7:0];
    endfunction
endpackage

// Behavioural EEPROM: decodes the command per chip-select window, serves
// image bytes after falling edges, and counts frames and malformed frames.
module ee_model (
    input  logic cs,
    input  logic sclk,
    input  logic mosi,
    output logic miso,
    output int   frames,
    output int   bad
);
    import tb_img_pkg::*;
    int          cnt;
    logic [13:0] cmd;
    logic        cs_p, sclk_p;
    logic [7:0]  b;

    initial begin
        miso = 1'b0; frames = 0; bad = 0; cnt = 0; cmd = '0;
        cs_p = 1'b0; sclk_p = 1'b0; b = '0;
    end

    always @(cs or sclk) begin
        if (cs && !cs_p) cnt = 0;
        if (!cs && cs_p) begin
            if (cnt != 22 || cmd[13:11] != 3'b110 || cmd[10:0] != 11'(frames)) bad = bad + 1;
            frames = frames + 1;
        end
        if (sclk && !sclk_p) begin
            if (!cs) bad = bad + 1;
            else begin
                if (cnt < 14) cmd = {cmd[12:0], mosi};
                cnt = cnt + 1;
            end
        end
        if (!sclk && sclk_p && cs && cnt >= 14 && cnt < 22) begin
            b = img_byte(int'(cmd[10:0]));
            miso = b[21 - cnt];
        end
        cs_p = cs;
        sclk_p = sclk;
    end
endmodule

// Port monitor: sampled on the falling system clock edge.
module link_mon (
    input  logic       clk,
    input  logic       cs,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic       done,
    output int         cs_rises,
    output int         writes,
    output int         order_bad,
    output int         mosi_bad,
    output int         hi_min,
    output int         hi_max,
    output int         gap_min,
    output int         gap_max,
    output int         early_done,
    output int         late_writes
);
    logic cs_p, sclk_p, mosi_p;
    int   hi_run, gap_run;
    initial begin
        cs_rises = 0; writes = 0; order_bad = 0; mosi_bad = 0;
        hi_min = 1000000; hi_max = 0; gap_min = 1000000; gap_max = 0;
        early_done = 0; late_writes = 0; hi_run = 0; gap_run = 0;
        cs_p = 0; sclk_p = 0; mosi_p = 0;
    end
    always @(negedge clk) begin
        if (cs && !cs_p) begin
            if (cs_rises > 0) begin
                if (gap_run < gap_min) gap_min = gap_run;
                if (gap_run > gap_max) gap_max = gap_run;
            end
            cs_rises = cs_rises + 1;
        end
        gap_run = cs ? 0 : gap_run + 1;
        if (sclk) hi_run = hi_run + 1;
        else if (sclk_p) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (sclk && mosi != mosi_p) mosi_bad = mosi_bad + 1;
        if (we) begin
            if (done) late_writes = late_writes + 1;
            if (int'(addr) != writes) order_bad = order_bad + 1;
            writes = writes + 1;
        end
        if (done && writes != 256) early_done = early_done + 1;
        cs_p = cs; sclk_p = sclk; mosi_p = mosi;
    end
endmodule

module tb_eeprom_boot_loader;
    import tb_img_pkg::*;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #5 clk = ~clk;

    logic       cs_a, sclk_a, mosi_a, miso_a, we_a, done_a;
    logic       cs_b, sclk_b, mosi_b, miso_b, we_b, done_b;
    logic [7:0] addr_a, wd_a, addr_b, wd_b;
    logic [7:0] ram_a [256];
    logic [7:0] ram_b [256];

    int frames_a, bad_a, frames_b, bad_b;
    int rises_a, wr_a, ord_a, mb_a, hmin_a, hmax_a, gmin_a, gmax_a, ed_a, lw_a;
    int rises_b, wr_b, ord_b, mb_b, hmin_b, hmax_b, gmin_b, gmax_b, ed_b, lw_b;
    int total = 0;
    int nbad = 0;
    bit finished = 0;

    eeprom_boot_loader #(.CLK_HALF_DIV(DIV), .END_PAUSE(1)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ee_cs(cs_a), .ee_sclk(sclk_a),
        .ee_mosi(mosi_a), .ee_miso(miso_a), .ram_we(we_a), .ram_addr(addr_a),
        .ram_wdata(wd_a), .done(done_a));

    eeprom_boot_loader #(.CLK_HALF_DIV(DIV), .END_PAUSE(0)) dut_np (
        .clk(clk), .rst_n(rst_n), .start(start), .ee_cs(cs_b), .ee_sclk(sclk_b),
        .ee_mosi(mosi_b), .ee_miso(miso_b), .ram_we(we_b), .ram_addr(addr_b),
        .ram_wdata(wd_b), .done(done_b));

    ee_model m_a (.cs(cs_a), .sclk(sclk_a), .mosi(mosi_a), .miso(miso_a), .frames(frames_a), .bad(bad_a));
    ee_model m_b (.cs(cs_b), .sclk(sclk_b), .mosi(mosi_b), .miso(miso_b), .frames(frames_b), .bad(bad_b));

    link_mon mon_a (.clk(clk), .cs(cs_a), .sclk(sclk_a), .mosi(mosi_a), .we(we_a), .addr(addr_a),
        .done(done_a), .cs_rises(rises_a), .writes(wr_a), .order_bad(ord_a), .mosi_bad(mb_a),
        .hi_min(hmin_a), .hi_max(hmax_a), .gap_min(gmin_a), .gap_max(gmax_a),
        .early_done(ed_a), .late_writes(lw_a));
    link_mon mon_b (.clk(clk), .cs(cs_b), .sclk(sclk_b), .mosi(mosi_b), .we(we_b), .addr(addr_b),
        .done(done_b), .cs_rises(rises_b), .writes(wr_b), .order_bad(ord_b), .mosi_bad(mb_b),
        .hi_min(hmin_b), .hi_max(hmax_b), .gap_min(gmin_b), .gap_max(gmax_b),
        .early_done(ed_b), .late_writes(lw_b));

    always @(negedge clk) begin
        if (we_a) ram_a[addr_a] = wd_a;
        if (we_b) ram_b[addr_b] = wd_b;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, nbad);
            $finish;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // R1: outputs while reset is held
    task automatic t_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({cs_a, sclk_a, mosi_a, we_a, done_a} == 5'b0, "R1", "outputs in reset",
            int'({cs_a, sclk_a, mosi_a, we_a, done_a}), 0);
        chk({cs_b, sclk_b, mosi_b, we_b, done_b} == 5'b0, "R1", "outputs in reset (no pause)",
            int'({cs_b, sclk_b, mosi_b, we_b, done_b}), 0);
    endtask

    // R2: no activity without start
    task automatic t_idle();
        @(negedge clk) rst_n = 1'b1;
        repeat (200) @(negedge clk);
        chk(rises_a == 0 && rises_b == 0, "R2", "cs rises before start", rises_a + rises_b, 0);
        chk(wr_a == 0 && wr_b == 0, "R2", "writes before start", wr_a + wr_b, 0);
    endtask

    // Full load with a stray start mid-way (R10)
    task automatic t_load();
        pulse_start();
        repeat (3000) @(negedge clk);
        pulse_start();
        while (!(done_a && done_b)) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(rises_a == 256, "R10", "cs rises despite extra start", rises_a, 256);
        chk(rises_b == 256, "R6", "one cs rise per byte (no pause)", rises_b, 256);
        chk(frames_a == 256 && frames_b == 256, "R4", "transactions seen", frames_a + frames_b, 512);
        chk(bad_a == 0, "R3", "malformed command/length frames", bad_a, 0);
        chk(bad_b == 0, "R4", "malformed frames (no pause)", bad_b, 0);
        chk(wr_a == 256 && wr_b == 256, "R8", "write count", wr_a + wr_b, 512);
        chk(ord_a == 0 && ord_b == 0, "R8", "out-of-order addresses", ord_a + ord_b, 0);
        chk(mb_a == 0 && mb_b == 0, "R5", "mosi change while sclk high", mb_a + mb_b, 0);
        chk(hmin_a == DIV && hmax_a == DIV, "R7", "sclk high length max", hmax_a, DIV);
        chk(hmin_b == DIV && hmax_b == DIV, "R7", "sclk high length min (no pause)", hmin_b, DIV);
        chk(gmin_b >= 1 && gmin_b == gmax_b, "R6", "cs low gap between bytes", gmin_b, gmax_b);
        chk(gmin_a == gmax_a && (gmin_a - gmin_b) == DIV, "R11", "gap difference",
            gmin_a - gmin_b, DIV);
        chk(ed_a == 0 && ed_b == 0, "R9", "done before last write", ed_a + ed_b, 0);
    endtask

    // R5/R8: RAM contents equal the image, byte 0 at address 0
    task automatic t_image();
        int mis_a = 0;
        int mis_b = 0;
        for (int i = 0; i < 256; i++) begin
            if (ram_a[i] !== img_byte(i)) mis_a++;
            if (ram_b[i] !== img_byte(i)) mis_b++;
        end
        chk(ram_a[0] === img_byte(0), "R8", "entry byte at 0x0000", int'(ram_a[0]), int'(img_byte(0)));
        chk(mis_a == 0, "R5", "RAM mismatches (pause)", mis_a, 0);
        chk(mis_b == 0, "R8", "RAM mismatches (no pause)", mis_b, 0);
    endtask

    // R9/R10: start after done is ignored, done holds
    task automatic t_after_done();
        pulse_start();
        repeat (500) @(negedge clk);
        chk(rises_a == 256 && rises_b == 256, "R10", "cs rises after done", rises_a + rises_b, 512);
        chk(wr_a == 256 && lw_a == 0 && lw_b == 0, "R9", "writes after done", lw_a + lw_b, 0);
        chk(done_a && done_b, "R9", "done held", int'(done_a) + int'(done_b), 2);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_load();
        t_image();
        t_after_done();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        nbad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end
endmodule